// File: doc/BRIEF.md
# Two-Wire Bus Single-Master Sequencer

This block runs a complete transaction on an open-drain two-wire serial bus on which it is the only master. A one-cycle request carries a 7-bit target address, a direction flag and a byte count. The block then produces the whole bus sequence and returns to idle. That sequence is the opening condition, the address frame with its direction bit, the acknowledge slot, the data frames and the closing condition. The block alone generates the clock line. Its rate comes from a quarter-bit divider that is derived from two parameters, the system clock frequency and the highest permitted bus frequency.

Both lines are only ever pulled low. The `*_oe` outputs request a low level, and a released line reads high through the external pull-up. In a write, the next byte is taken from `wdata` at the start of each data frame, and a `wdata_take` pulse tells the user that the next byte may be presented. In a read, each received byte appears on `rdata` with a one-cycle `rdata_valid` pulse. The master acknowledges every received byte except the final one. A missing acknowledge from the target ends the transaction early and sets a flag.

Top module: `i2c_host`

## Requirements
- R1: After reset `busy`, `done`, `nack_err`, `scl_oe` and `sda_oe` are all 0, so both lines are released.
- R2: Every bit lasts 4*Q clocks, with SCL low for the first 2*Q and released for the last 2*Q. Q is the smallest integer with 4*Q*BUS_HZ >= CLK_HZ, so the bus never runs faster than BUS_HZ.
- R3: A `start` seen while idle latches `addr`, `rd` and `nbytes`. The block then pulls SDA low while SCL is high and sends the 7 address bits MSB first, followed by the direction bit (1 = read, 0 = write).
- R4: SDA changes while SCL is released only for the single opening condition and the single closing condition of each transaction.
- R5: In a write, `wdata` is latched at the start of each data frame, with `wdata_take` pulsing once per latched byte. The byte is sent MSB first, and the target's acknowledge is sampled in the 9th clock.
- R6: In a read, bits are shifted in MSB first, and `rdata_valid` pulses with the byte after its 8th bit. In the 9th clock the master pulls SDA low for every byte except the last, where it leaves SDA released.
- R7: A released SDA in an acknowledge slot owned by the target (after the address or after a write byte) sets `nack_err` and sends no further bytes. The block then closes the transaction. `nack_err` holds until the next accepted `start`.
- R8: A transaction ends with SDA rising while SCL is released. Then `done` pulses for one cycle, and `busy` is already 0 in that cycle.
- R9: With `nbytes` = 0 only the address frame is sent, followed by the closing condition.
- R10: A `start` in the cycle where `done` pulses begins a new transaction. A `start` while busy is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Transaction request pulse |
| addr | input | 7 | Target address |
| rd | input | 1 | 1 = read, 0 = write |
| nbytes | input | CNT_W | Data bytes to move |
| wdata | input | 8 | Next byte to write |
| wdata_take | output | 1 | Pulse: `wdata` has been latched |
| rdata | output | 8 | Last received byte |
| rdata_valid | output | 1 | Pulse: `rdata` is new |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | Pulse: transaction finished |
| nack_err | output | 1 | Missing acknowledge seen |
| scl_oe | output | 1 | 1 pulls the clock line low |
| sda_oe | output | 1 | 1 pulls the data line low |
| scl_in | input | 1 | Clock line level |
| sda_in | input | 1 | Data line level |

## Verification
The end of one transaction and the acceptance of the next can fall in the same cycle: `done` is high, the sequencer is already idle, and `start` is asserted. The bench watches for `done` at the falling clock edge and drives `start` in that very cycle. One cycle later it expects `busy` to be high, and it then checks that the following read delivers its byte. Earlier in the same scenario it issues a conflicting `start` in the middle of a write, and it confirms that the target still logs the original address and bytes with no read data.

// File: rtl/i2c_host_pkg.sv
package i2c_host_pkg;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_START,
    ST_XFER,
    ST_STOP
  } bus_state_t;

  // clocks per quarter bit, rounded up so the bus never exceeds bus_hz
  function automatic int unsigned qtr_cycles(input int unsigned clk_hz,
                                             input int unsigned bus_hz);
    int unsigned q;
    q = (clk_hz + 4 * bus_hz - 1) / (4 * bus_hz);
    return (q == 0) ? 1 : q;
  endfunction

  // level the master wants on SDA for the current bit (1 = released)
  function automatic logic bus_level(input logic ack_slot, input logic talk,
                                     input logic msb, input logic last);
    if (!ack_slot) return talk ? msb : 1'b1;
    return talk ? 1'b1 : last;
  endfunction

endpackage

// File: rtl/i2c_host_tick.sv
module i2c_host_tick #(
  parameter int unsigned QTR = 4
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       run,
  output logic       tick,
  output logic [1:0] qtr
);
  localparam int CW = (QTR > 1) ? $clog2(QTR) : 1;

  logic [CW-1:0] cnt;

  assign tick = run && (cnt == CW'(QTR - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt <= '0;
      qtr <= 2'd0;
    end else if (!run) begin
      cnt <= '0;
      qtr <= 2'd0;
    end else if (tick) begin
      cnt <= '0;
      qtr <= qtr + 2'd1;
    end else begin
      cnt <= cnt + CW'(1);
    end
  end

  // R2
  cnt_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    32'(cnt) < QTR);

  // R2
  qtr_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (qtr == 2'd0) || run);

endmodule

// File: rtl/i2c_host_shift.sv
module i2c_host_shift #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] ld_val,
  input  logic         shift,
  input  logic         sin,
  output logic [W-1:0] q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     q <= '0;
    else if (load)  q <= ld_val;
    else if (shift) q <= {q[W-2:0], sin};
  end

  // R3
  ld_sh_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(load && shift));

endmodule

// File: rtl/i2c_host.sv
module i2c_host
  import i2c_host_pkg::*;
#(
  parameter int unsigned CLK_HZ = 50_000_000,
  parameter int unsigned BUS_HZ = 100_000,
  parameter int unsigned CNT_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic [6:0]       addr,
  input  logic             rd,
  input  logic [CNT_W-1:0] nbytes,
  input  logic [7:0]       wdata,
  output logic             wdata_take,
  output logic [7:0]       rdata,
  output logic             rdata_valid,
  output logic             busy,
  output logic             done,
  output logic             nack_err,
  output logic             scl_oe,
  output logic             sda_oe,
  input  logic             scl_in,
  input  logic             sda_in
);
  localparam int unsigned QTR   = qtr_cycles(CLK_HZ, BUS_HZ);
  localparam int          BIT_W = 4;
  localparam logic [BIT_W-1:0] ACK_IDX = BIT_W'(8);
  localparam logic [BIT_W-1:0] LSB_IDX = BIT_W'(7);

  bus_state_t       state_q;
  logic [BIT_W-1:0] bidx;
  logic [CNT_W-1:0] rem;
  logic             dir_rd, is_addr, nack_pend, sda_drv;
  logic [7:0]       sh_q;

  // named internal events
  logic       tick;
  logic [1:0] qtr;
  logic       accept, in_xfer, smp_evt, bit_end, byte_end;
  logic       ack_slot, talk, last_rd, fin, take_now, want_level;

  assign busy     = (state_q != ST_IDLE);
  assign accept   = (state_q == ST_IDLE) && start;
  assign in_xfer  = (state_q == ST_XFER);
  assign smp_evt  = in_xfer && tick && (qtr == 2'd2) && scl_in;
  assign bit_end  = in_xfer && tick && (qtr == 2'd3);
  assign ack_slot = (bidx == ACK_IDX);
  assign byte_end = bit_end && ack_slot;
  assign talk     = is_addr || !dir_rd;
  assign last_rd  = (rem == CNT_W'(1));
  assign fin      = is_addr ? (rem == '0) : last_rd;
  assign take_now = byte_end && !nack_pend && !fin && !dir_rd;
  assign want_level = bus_level(ack_slot, talk, sh_q[7], last_rd);

  assign scl_oe = ((state_q == ST_XFER) || (state_q == ST_STOP)) && !qtr[1];
  assign sda_oe = sda_drv;

  i2c_host_tick #(.QTR(QTR)) u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .tick (tick),
    .qtr  (qtr)
  );

  i2c_host_shift #(.W(8)) u_shift (
    .clk   (clk),
    .rst_n (rst_n),
    .load  (accept || take_now),
    .ld_val(accept ? {addr, rd} : wdata),
    .shift (smp_evt && !ack_slot),
    .sin   (sda_in),
    .q     (sh_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      bidx        <= '0;
      rem         <= '0;
      dir_rd      <= 1'b0;
      is_addr     <= 1'b0;
      nack_pend   <= 1'b0;
      nack_err    <= 1'b0;
      sda_drv     <= 1'b0;
      done        <= 1'b0;
      wdata_take  <= 1'b0;
      rdata       <= '0;
      rdata_valid <= 1'b0;
    end else begin
      done        <= 1'b0;
      wdata_take  <= 1'b0;
      rdata_valid <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (start) begin
            state_q   <= ST_START;
            dir_rd    <= rd;
            rem       <= nbytes;
            is_addr   <= 1'b1;
            bidx      <= '0;
            nack_pend <= 1'b0;
            nack_err  <= 1'b0;
          end
        end
        ST_START: begin
          if (tick) begin
            if (qtr == 2'd1) sda_drv <= 1'b1;      // SDA falls, SCL high
            if (qtr == 2'd3) state_q <= ST_XFER;
          end
        end
        ST_XFER: begin
          if (tick && qtr == 2'd0) sda_drv <= !want_level;
          if (smp_evt) begin
            if (bidx == LSB_IDX && !is_addr && dir_rd) begin
              rdata       <= {sh_q[6:0], sda_in};
              rdata_valid <= 1'b1;
            end
            if (ack_slot && talk && sda_in) begin
              nack_pend <= 1'b1;
              nack_err  <= 1'b1;
            end
          end
          if (bit_end) begin
            if (!ack_slot) begin
              bidx <= bidx + BIT_W'(1);
            end else begin
              bidx    <= '0;
              is_addr <= 1'b0;
              if (!is_addr) rem <= rem - CNT_W'(1);
              if (nack_pend || fin) state_q <= ST_STOP;
              wdata_take <= take_now;
            end
          end
        end
        ST_STOP: begin
          if (tick) begin
            if (qtr == 2'd0) sda_drv <= 1'b1;
            if (qtr == 2'd2) sda_drv <= 1'b0;      // SDA rises, SCL high
            if (qtr == 2'd3) begin
              state_q   <= ST_IDLE;
              done      <= 1'b1;
              nack_pend <= 1'b0;
            end
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  // R4
  sda_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!scl_oe && !$past(scl_oe) && (sda_oe != $past(sda_oe)))
      |-> (state_q == ST_START || state_q == ST_STOP));

  // R8
  done_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (state_q == ST_IDLE && !sda_oe && !scl_oe));

  // R7
  nack_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_end && nack_pend) |=> (state_q == ST_STOP));

  // R10
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_IDLE && !start) |=> (state_q == ST_IDLE));

  // R5
  take_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wdata_take |-> !dir_rd);

  // R6
  rdv_dir_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rdata_valid |-> dir_rd);

  // R6
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({wdata_take, rdata_valid, done}));

endmodule

// File: tb/sim_i2c_host.sv
`timescale 1ns/1ps
module sim_i2c_host;
  localparam int unsigned CLK_HZ = 1_700_000;
  localparam int unsigned BUS_HZ = 100_000;
  localparam int unsigned CNT_W  = 8;
  localparam logic [6:0]  T_ADDR = 7'h5A;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic start = 1'b0;
  logic [6:0] addr = '0;
  logic rd = 1'b0;
  logic [CNT_W-1:0] nbytes = '0;
  logic [7:0] wdata;
  logic wdata_take, rdata_valid, busy, done, nack_err, scl_oe, sda_oe;
  logic [7:0] rdata;
  logic scl_b, sda_b;
  logic t_pull = 1'b0;

  always #2 clk = ~clk;

  assign scl_b = ~scl_oe;
  assign sda_b = ~(sda_oe | t_pull);

  i2c_host #(.CLK_HZ(CLK_HZ), .BUS_HZ(BUS_HZ), .CNT_W(CNT_W)) u0 (
    .clk(clk), .rst_n(rst_n), .start(start), .addr(addr), .rd(rd),
    .nbytes(nbytes), .wdata(wdata), .wdata_take(wdata_take),
    .rdata(rdata), .rdata_valid(rdata_valid), .busy(busy), .done(done),
    .nack_err(nack_err), .scl_oe(scl_oe), .sda_oe(sda_oe),
    .scl_in(scl_b), .sda_in(sda_b)
  );

  int n_chk = 0;
  int n_fail = 0;
  int qexp;

  // write data source
  logic [7:0] wsrc [0:63];
  int widx = 0;
  assign wdata = wsrc[widx];

  // read capture and pulse counts
  logic [7:0] rlog [0:63];
  int rcnt = 0;
  int ndone = 0;
  always @(negedge clk) begin
    if (wdata_take) widx = widx + 1;
    if (rdata_valid) begin rlog[rcnt] = rdata; rcnt = rcnt + 1; end
    if (done) ndone = ndone + 1;
  end

  int cyc = 0;
  always @(posedge clk) cyc = cyc + 1;

  // behavioural target
  logic [7:0] mem [0:63];
  logic [7:0] wlog [0:63];
  logic       macks [0:63];
  int nstart = 0, nstop = 0, bc = 0, ri = 0, wcnt = 0;
  int nack_at = -1;
  int t_rise = 0, per_last = 0, hi_last = 0;
  logic p_scl = 1'b1, p_sda = 1'b1;
  logic first = 1'b0, t_sel = 1'b0, t_rd = 1'b0, m_ack = 1'b0;
  logic [7:0] shin = '0, rbyte = '0;
  logic [6:0] seen_addr = '0;
  logic seen_rw = 1'b0;

  always @(scl_b or sda_b) begin
    if (scl_b === 1'b1 && p_scl === 1'b1 && p_sda === 1'b1 && sda_b === 1'b0) begin
      nstart = nstart + 1; bc = 0; first = 1'b1; t_sel = 1'b0; t_pull = 1'b0;
    end else if (scl_b === 1'b1 && p_scl === 1'b1 && p_sda === 1'b0 && sda_b === 1'b1) begin
      nstop = nstop + 1; t_sel = 1'b0; t_pull = 1'b0;
    end else if (p_scl === 1'b0 && scl_b === 1'b1) begin
      per_last = cyc - t_rise; t_rise = cyc;
      if (bc < 8) shin = {shin[6:0], sda_b};
      else if (!first && t_sel && t_rd) begin
        m_ack = !sda_b;
        if (ri > 0) macks[ri-1] = m_ack;
      end
      bc = bc + 1;
    end else if (p_scl === 1'b1 && scl_b === 1'b0) begin
      hi_last = cyc - t_rise;
      if (bc == 8) begin
        if (first) begin
          seen_addr = shin[7:1]; seen_rw = shin[0];
          if (shin[7:1] == T_ADDR) begin t_sel = 1'b1; t_rd = shin[0]; t_pull = 1'b1; end
          else t_pull = 1'b0;
        end else if (t_sel && !t_rd) begin
          wlog[wcnt] = shin; t_pull = (wcnt != nack_at); wcnt = wcnt + 1;
        end else t_pull = 1'b0;
      end else if (bc == 9) begin
        bc = 0;
        if (t_sel && t_rd && (first || m_ack)) begin
          rbyte = mem[ri]; ri = ri + 1; t_pull = !rbyte[7];
        end else t_pull = 1'b0;
        first = 1'b0;
      end else if (t_sel && t_rd && !first && bc > 0 && bc < 8) begin
        t_pull = !rbyte[7-bc];
      end else t_pull = 1'b0;
    end
    p_scl = scl_b; p_sda = sda_b;
  end

  task automatic chk(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic pulse_start(input logic [6:0] a, input logic r, input int n);
    addr = a; rd = r; nbytes = CNT_W'(n); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done();
    int guard = 0;
    while (!done && guard < 30000) begin @(negedge clk); guard++; end
  endtask

  task automatic t_reset();
    chk("R1 busy", int'(busy), 0);
    chk("R1 done", int'(done), 0);
    chk("R1 nack_err", int'(nack_err), 0);
    chk("R1 scl_oe", int'(scl_oe), 0);
    chk("R1 sda_oe", int'(sda_oe), 0);
  endtask

  task automatic t_write();
    int w0 = wcnt, s0 = nstart, p0 = nstop, d0 = ndone, k0 = widx;
    wsrc[widx] = 8'hA5; wsrc[widx+1] = 8'h3C; wsrc[widx+2] = 8'hFF;
    @(negedge clk);
    pulse_start(T_ADDR, 1'b0, 3);
    wait_done();
    chk("R8 busy low with done", int'(busy), 0);
    chk("R3 address", int'(seen_addr), int'(T_ADDR));
    chk("R3 dir write", int'(seen_rw), 0);
    chk("R5 bytes logged", wcnt - w0, 3);
    chk("R5 byte0", int'(wlog[w0]), 8'hA5);
    chk("R5 byte1", int'(wlog[w0+1]), 8'h3C);
    chk("R5 byte2", int'(wlog[w0+2]), 8'hFF);
    chk("R5 takes", widx - k0, 3);
    chk("R5 no nack", int'(nack_err), 0);
    chk("R4 one start", nstart - s0, 1);
    chk("R8 one stop", nstop - p0, 1);
    chk("R2 bit period", per_last, 4 * qexp);
    chk("R2 high time", hi_last, 2 * qexp);
    @(negedge clk);
    chk("R8 done count", ndone - d0, 1);
  endtask

  task automatic t_read();
    int r0 = rcnt, m0 = ri, k0 = widx;
    mem[ri] = 8'h96; mem[ri+1] = 8'h01; mem[ri+2] = 8'hC3;
    @(negedge clk);
    pulse_start(T_ADDR, 1'b1, 3);
    wait_done();
    chk("R3 dir read", int'(seen_rw), 1);
    chk("R6 bytes read", rcnt - r0, 3);
    chk("R6 rbyte0", int'(rlog[r0]), 8'h96);
    chk("R6 rbyte1", int'(rlog[r0+1]), 8'h01);
    chk("R6 rbyte2", int'(rlog[r0+2]), 8'hC3);
    chk("R6 ack0", int'(macks[m0]), 1);
    chk("R6 ack1", int'(macks[m0+1]), 1);
    chk("R6 last nack", int'(macks[m0+2]), 0);
    chk("R6 no takes", widx - k0, 0);
  endtask

  task automatic t_addr_nack();
    int w0 = wcnt, p0 = nstop, k0 = widx;
    wsrc[widx] = 8'h12; wsrc[widx+1] = 8'h34;
    @(negedge clk);
    pulse_start(7'h11, 1'b0, 2);
    wait_done();
    chk("R7 addr nack flag", int'(nack_err), 1);
    chk("R7 no data sent", wcnt - w0, 0);
    chk("R7 no takes", widx - k0, 0);
    chk("R7 stop issued", nstop - p0, 1);
    repeat (5) @(negedge clk);
    chk("R7 flag held", int'(nack_err), 1);
  endtask

  task automatic t_data_nack();
    int w0 = wcnt, k0 = widx;
    nack_at = wcnt + 1;
    wsrc[widx] = 8'h11; wsrc[widx+1] = 8'h22; wsrc[widx+2] = 8'h33; wsrc[widx+3] = 8'h44;
    @(negedge clk);
    pulse_start(T_ADDR, 1'b0, 4);
    wait_done();
    nack_at = -1;
    chk("R7 data nack flag", int'(nack_err), 1);
    chk("R7 bytes before abort", wcnt - w0, 2);
    chk("R7 takes before abort", widx - k0, 2);
  endtask

  task automatic t_zero();
    int s0 = nstart, p0 = nstop, k0 = widx, w0 = wcnt;
    @(negedge clk);
    pulse_start(T_ADDR, 1'b0, 0);
    @(negedge clk);
    chk("R7 flag cleared by start", int'(nack_err), 0);
    wait_done();
    chk("R9 address only", int'(seen_addr), int'(T_ADDR));
    chk("R9 no data", wcnt - w0, 0);
    chk("R9 no takes", widx - k0, 0);
    chk("R9 start", nstart - s0, 1);
    chk("R9 stop", nstop - p0, 1);
  endtask

  task automatic t_b2b();
    int w0 = wcnt, r0 = rcnt, s0 = nstart, m0 = ri;
    wsrc[widx] = 8'h5E; wsrc[widx+1] = 8'hC1;
    mem[ri] = 8'h7B;
    @(negedge clk);
    pulse_start(T_ADDR, 1'b0, 2);
    repeat (120) @(negedge clk);
    pulse_start(7'h11, 1'b1, 5);          // R10: ignored while busy
    wait_done();
    chk("R10 busy start ignored wr", wcnt - w0, 2);
    chk("R10 busy start ignored rd", rcnt - r0, 0);
    chk("R10 address kept", int'(seen_addr), int'(T_ADDR));
    pulse_start(T_ADDR, 1'b1, 1);         // start in the done cycle
    chk("R10 accepted at done", int'(busy), 1);
    wait_done();
    chk("R10 second xfer byte count", rcnt - r0, 1);
    chk("R10 second xfer byte", int'(rlog[r0]), int'(mem[m0]));
    chk("R10 two starts", nstart - s0, 2);
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin wsrc[i] = '0; mem[i] = '0; end
    qexp = 1;
    while (4 * qexp * BUS_HZ < CLK_HZ) qexp++;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_write();
    t_read();
    t_addr_nack();
    t_data_nack();
    t_zero();
    t_b2b();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule